// File: doc/BRIEF.md
# AXI4 Write-to-Network Flit Injector

This block sits between an AXI4 write master and one injection port of a virtual-channel on-chip network. It accepts one write burst at a time on the AW, W and B channels. Each accepted data beat becomes exactly one network flit, so the flit payload is as wide as the AXI data bus. The flit carries a tail marker, a destination receive-port number, a virtual-channel number and the payload.

The network does not use credits. Every cycle it returns one not-full bit per virtual channel. A flit may be sent only on a channel whose bit is set in that same cycle. The injection port is always ready and takes a flit with a valid tag on every cycle, and the tag stays low when nothing is sent. The destination port is the low bits of the write address. The read channels are permanently idle.

A three-state sequencer handles the write. It waits for an address, moves the data beats, then holds the response until the master takes it. Only one write is ever outstanding.

Top module: `axi_wr_flit_bridge`

## Requirements
- R1: The flit is packed with the tail flag in the MSB, then the destination (DST_W bits), then the VC number (VC_W bits), with the payload in the low DATA_W bits. With the default parameters these fields sit at [67], [66:65], [64] and [63:0].
- R2: In the cycle a W beat is accepted (w_valid and w_ready both high), flit_valid is high and the flit payload equals w_data. In every other cycle flit_valid is low.
- R3: The flit goes out on the lowest-numbered VC whose vc_not_full bit is set in that cycle. It is never sent on a VC whose bit is clear.
- R4: w_ready is low whenever no vc_not_full bit is set, and whenever no write address is pending.
- R5: The flit's destination field equals aw_addr[DST_W-1:0], captured at the AW handshake.
- R6: The tail flag is set on the beat that has w_last high, or on beat number aw_len+1 even if w_last is low. A single-beat write therefore has its tail set. The tail flag is clear on all other beats.
- R7: aw_ready is high while the block is idle. It is low from the cycle after the AW handshake until the cycle after the B handshake.
- R8: b_valid rises in the cycle after the tail beat is accepted. While b_valid is high, b_resp is 2'b00 (OKAY) and b_id equals the captured aw_id. Both hold until b_ready is seen.
- R9: ar_ready and r_valid are always 0.
- R10: After reset, aw_ready is 1 and w_ready, b_valid and flit_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write address; low bits select the destination |
| aw_len | input | 8 | Beats minus one |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write data beat |
| w_last | input | 1 | Final beat marker |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | ID_W | Response ID |
| b_resp | output | 2 | Response code, always OKAY |
| ar_ready | output | 1 | Read address ready, tied to 0 |
| r_valid | output | 1 | Read data valid, tied to 0 |
| vc_not_full | input | NUM_VCS | Per-VC space indication from the network |
| flit_valid | output | 1 | Flit valid tag |
| flit_out | output | FLIT_W | Packed flit |

## Verification
Flit formation, w_ready and the VC choice are combinational from the W inputs and vc_not_full. They are due in the same cycle as the stimulus, so the bench changes inputs on the falling edge and samples 1 ns later, before the rising edge. The register-driven results (aw_ready dropping, b_valid rising, aw_ready returning) are due one rising edge after their handshake. These are sampled just after the next falling edge. Random not-full patterns, including the all-clear case, stall beats for random numbers of cycles. Directed cases cover single-beat writes and a burst whose final beat lacks w_last.

// File: rtl/axi_flit_pkg.sv
// Shared definitions for the AXI write to flit injector.
// Assumes AXI4 response encoding with OKAY = 2'b00.
package axi_flit_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_DATA = 2'd1,
        SEQ_RESP = 2'd2
    } seq_state_t;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/vc_lowest_pick.sv
// Chooses the lowest-numbered virtual channel whose not-full bit is set.
// Assumes N >= 1; idx is don't-care (zero) when no bit is set.
module vc_lowest_pick #(
    parameter int N    = 2,
    parameter int IDXW = 1
) (
    input  logic [N-1:0]    nf,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    // Priority scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (nf[i]) idx = IDXW'(i);
        end
    end

    // Injection is possible when any channel has space.
    assign any = |nf;
endmodule

// File: rtl/flit_former.sv
// Packs the flit fields: tail at the MSB, then destination, VC, payload.
// Assumes field widths are fixed by parameters at elaboration.
module flit_former #(
    parameter int DATA_W = 64,
    parameter int DST_W  = 2,
    parameter int VC_W   = 1,
    localparam int FLIT_W = 1 + DST_W + VC_W + DATA_W
) (
    input  logic              tail,
    input  logic [DST_W-1:0]  dst,
    input  logic [VC_W-1:0]   vc,
    input  logic [DATA_W-1:0] data,
    output logic [FLIT_W-1:0] flit
);
    // Field concatenation in network order.
    assign flit = {tail, dst, vc, data};
endmodule

// File: rtl/wr_seq_fsm.sv
// Sequences one AXI write: address capture, data beats, response.
// Assumes the caller gates beat acceptance through vc_avail; one write
// is outstanding at a time.
module wr_seq_fsm #(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int DST_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [7:0]        aw_len,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic              w_last,
    input  logic              vc_avail,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [ID_W-1:0]   b_id,
    output logic              tail,
    output logic [DST_W-1:0]  dst
);
    import axi_flit_pkg::*;

    seq_state_t      state;
    logic [7:0]      beats_left;
    logic [ID_W-1:0] id_q;
    logic [DST_W-1:0] dst_q;
    logic            beat_hs;

    // Handshake and end-of-burst decode.
    always_comb begin
        aw_ready = (state == SEQ_IDLE);
        w_ready  = (state == SEQ_DATA) && vc_avail;
        b_valid  = (state == SEQ_RESP);
        beat_hs  = w_valid && w_ready;
        tail     = w_last || (beats_left == 8'd0);
    end

    // State, captured ID, destination and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            beats_left <= '0;
            id_q       <= '0;
            dst_q      <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (aw_valid) begin
                    id_q       <= aw_id;
                    dst_q      <= aw_addr[DST_W-1:0];
                    beats_left <= aw_len;
                    state      <= SEQ_DATA;
                end
                SEQ_DATA: if (beat_hs) begin
                    beats_left <= beats_left - 8'd1;
                    if (tail) state <= SEQ_RESP;
                end
                SEQ_RESP: if (b_ready) state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    assign b_id = id_q;
    assign dst  = dst_q;
endmodule

// File: rtl/axi_wr_flit_bridge.sv
// Top: turns AXI4 write bursts into network flits on one injection port
// with per-VC not-full flow control. Assumes payload width equals the AXI
// data width (one beat per flit); the read channels are tied off.
module axi_wr_flit_bridge #(
    parameter int DATA_W  = 64,
    parameter int ID_W    = 4,
    parameter int ADDR_W  = 32,
    parameter int NUM_PORTS = 4,
    parameter int NUM_VCS = 2,
    localparam int DST_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int VC_W   = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1,
    localparam int FLIT_W = 1 + DST_W + VC_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               aw_valid,
    output logic               aw_ready,
    input  logic [ID_W-1:0]    aw_id,
    input  logic [ADDR_W-1:0]  aw_addr,
    input  logic [7:0]         aw_len,
    input  logic               w_valid,
    output logic               w_ready,
    input  logic [DATA_W-1:0]  w_data,
    input  logic               w_last,
    output logic               b_valid,
    input  logic               b_ready,
    output logic [ID_W-1:0]    b_id,
    output logic [1:0]         b_resp,
    output logic               ar_ready,
    output logic               r_valid,
    input  logic [NUM_VCS-1:0] vc_not_full,
    output logic               flit_valid,
    output logic [FLIT_W-1:0]  flit_out
);
    import axi_flit_pkg::*;

    logic             vc_avail;
    logic [VC_W-1:0]  vc_sel;
    logic             tail;
    logic [DST_W-1:0] dst;

    vc_lowest_pick #(.N(NUM_VCS), .IDXW(VC_W)) u_pick (
        .nf  (vc_not_full),
        .any (vc_avail),
        .idx (vc_sel)
    );

    wr_seq_fsm #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DST_W(DST_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .aw_valid (aw_valid),
        .aw_ready (aw_ready),
        .aw_id    (aw_id),
        .aw_addr  (aw_addr),
        .aw_len   (aw_len),
        .w_valid  (w_valid),
        .w_ready  (w_ready),
        .w_last   (w_last),
        .vc_avail (vc_avail),
        .b_valid  (b_valid),
        .b_ready  (b_ready),
        .b_id     (b_id),
        .tail     (tail),
        .dst      (dst)
    );

    flit_former #(.DATA_W(DATA_W), .DST_W(DST_W), .VC_W(VC_W)) u_form (
        .tail (tail),
        .dst  (dst),
        .vc   (vc_sel),
        .data (w_data),
        .flit (flit_out)
    );

    // A flit is injected exactly when a beat is accepted.
    assign flit_valid = w_valid && w_ready;
    assign b_resp     = RESP_OKAY;
    assign ar_ready   = 1'b0;
    assign r_valid    = 1'b0;
endmodule

// File: rtl/axi_wr_flit_bridge_chk.sv
// Checker for axi_wr_flit_bridge: protocol and flow-control properties.
// Assumes it is bound to the top with matching parameters.
module axi_wr_flit_bridge_chk #(
    parameter int DATA_W  = 64,
    parameter int ID_W    = 4,
    parameter int NUM_VCS = 2,
    parameter int DST_W   = 2,
    parameter int VC_W    = 1,
    parameter int FLIT_W  = 68
) (
    input logic               clk,
    input logic               rst_n,
    input logic               aw_ready,
    input logic               w_valid,
    input logic               w_ready,
    input logic               b_valid,
    input logic               b_ready,
    input logic [ID_W-1:0]    b_id,
    input logic [1:0]         b_resp,
    input logic               ar_ready,
    input logic               r_valid,
    input logic [NUM_VCS-1:0] vc_not_full,
    input logic               flit_valid,
    input logic [FLIT_W-1:0]  flit_out
);
    // R3: the chosen VC has space
    p_vc_has_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid |-> vc_not_full[flit_out[DATA_W +: VC_W]]);

    // R4: no data acceptance with every VC full
    p_stall_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vc_not_full == '0) |-> !w_ready);

    // R2: a flit only accompanies an accepted beat
    p_flit_on_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid |-> (w_valid && w_ready));

    // R7: no new address while a response is pending
    p_single_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> !aw_ready);

    // R8: response holds with stable ID until taken
    p_resp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_id)));

    // R8: response code is OKAY
    p_resp_okay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (b_resp == 2'b00));

    // R9: read channels stay idle
    p_read_tied_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ar_ready && !r_valid);
endmodule

bind axi_wr_flit_bridge axi_wr_flit_bridge_chk #(
    .DATA_W(DATA_W), .ID_W(ID_W), .NUM_VCS(NUM_VCS),
    .DST_W(DST_W), .VC_W(VC_W), .FLIT_W(FLIT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_ready(w_ready),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .ar_ready(ar_ready), .r_valid(r_valid), .vc_not_full(vc_not_full),
    .flit_valid(flit_valid), .flit_out(flit_out)
);

// File: tb/tb_axi_wr_flit_bridge.sv
module tb_axi_wr_flit_bridge;
    localparam int DATA_W = 64, ID_W = 4, ADDR_W = 32, NUM_PORTS = 4, NUM_VCS = 2;
    localparam int DST_W = 2, VC_W = 1, FLIT_W = 1 + DST_W + VC_W + DATA_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic aw_valid = 0, aw_ready; logic [ID_W-1:0] aw_id = '0;
    logic [ADDR_W-1:0] aw_addr = '0; logic [7:0] aw_len = '0;
    logic w_valid = 0, w_ready, w_last = 0; logic [DATA_W-1:0] w_data = '0;
    logic b_valid, b_ready = 0; logic [ID_W-1:0] b_id; logic [1:0] b_resp;
    logic ar_ready, r_valid; logic [NUM_VCS-1:0] vc_not_full = '0;
    logic flit_valid; logic [FLIT_W-1:0] flit_out;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    axi_wr_flit_bridge #(.DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W),
        .NUM_PORTS(NUM_PORTS), .NUM_VCS(NUM_VCS)) dut (.*);

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [VC_W-1:0] low_vc(logic [NUM_VCS-1:0] nf);
        for (int i = 0; i < NUM_VCS; i++) if (nf[i]) return VC_W'(i);
        return '0;
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_write(logic [ID_W-1:0] id, logic [ADDR_W-1:0] addr,
                            int len, bit drop_last, int bwait);
        @(negedge clk);
        aw_valid = 1; aw_id = id; aw_addr = addr; aw_len = 8'(len);
        #1 chk("R7 aw_ready idle", aw_ready, 1);
        @(negedge clk);
        aw_valid = 0;
        for (int b = 0; b <= len; b++) begin
            logic [DATA_W-1:0] d = {$urandom, $urandom};
            bit done = 0;
            while (!done) begin
                logic [NUM_VCS-1:0] nf = NUM_VCS'($urandom_range(0, 3));
                vc_not_full = nf; w_valid = 1; w_data = d;
                w_last = (b == len) && !drop_last;
                #1;
                chk("R7 aw_ready busy", aw_ready, 0);
                chk("R9 read tie-off", {ar_ready, r_valid}, 0);
                if (nf == 0) begin
                    chk("R4 w_ready all full", w_ready, 0);
                    chk("R2 no flit on stall", flit_valid, 0);
                end else begin
                    chk("R2 flit_valid", flit_valid, 1);
                    chk("R2 payload", flit_out[DATA_W-1:0], d);
                    chk("R3 lowest vc", flit_out[DATA_W +: VC_W], low_vc(nf));
                    chk("R5 dst", flit_out[DATA_W+VC_W +: DST_W], addr[DST_W-1:0]);
                    chk("R6 tail", flit_out[FLIT_W-1], (b == len));
                    chk("R1 flit pack", flit_out,
                        {(b == len) ? 1'b1 : 1'b0, addr[DST_W-1:0], low_vc(nf), d});
                    done = 1;
                end
                @(negedge clk);
            end
        end
        w_valid = 0; w_last = 0;
        #1;
        chk("R8 b_valid", b_valid, 1);
        chk("R8 b_id", b_id, id);
        chk("R8 b_resp", b_resp, 2'b00);
        chk("R2 idle flit", flit_valid, 0);
        for (int k = 0; k < bwait; k++) begin
            @(negedge clk); #1;
            chk("R8 b hold", {b_valid, b_id}, {1'b1, id});
            chk("R7 aw_ready during resp", aw_ready, 0);
        end
        b_ready = 1;
        @(negedge clk);
        b_ready = 0;
        #1;
        chk("R8 b_valid cleared", b_valid, 0);
        chk("R7 aw_ready back", aw_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R10 reset aw_ready", aw_ready, 1);
        chk("R10 reset w_ready", w_ready, 0);
        chk("R10 reset b_valid", b_valid, 0);
        chk("R10 reset flit_valid", flit_valid, 0);
        // R4: data offered with no address pending
        @(negedge clk);
        w_valid = 1; vc_not_full = '1; w_data = 64'hdead;
        #1 chk("R4 no address pending", w_ready, 0);
        chk("R2 no flit without address", flit_valid, 0);
        @(negedge clk); w_valid = 0;
        // Directed: single beat (R6), burst without w_last (R6), long stall
        do_write(4'h3, 32'h0000_0001, 0, 0, 0);
        do_write(4'hA, 32'h0000_0012, 1, 1, 3);
        do_write(4'h5, 32'h0000_0003, 3, 0, 1);
        // Random writes
        for (int t = 0; t < 40; t++)
            do_write(ID_W'($urandom), $urandom, $urandom_range(0, 5),
                     bit'($urandom_range(0, 3) == 0), $urandom_range(0, 3));
        report();
    end
endmodule